// File: doc/BRIEF.md
# Keyboard Input Port

This block sits between a character source and a processor's register bus. Characters arrive on a valid/ready stream and are held in a one-character data register. A status register announces that a character is waiting through its top bit, and an interrupt-enable bit beside it gates an interrupt request toward the processor. Once a character is held, the stream sees back-pressure. Only a read of the data register frees the holding slot, and that read clears the waiting flag as a side effect, so software needs no acknowledge write.

Flow control on the stream works as follows. A character is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for as long as a character is waiting. While `in_ready` is low, the source must hold `in_valid` and `in_data`. The bus is a single-cycle select/write-enable port with combinational read data. A read has its effect on the clock edge that ends the cycle in which `bus_sel` is high.

Top module: `kbd_input_port`

## Requirements
- R1: After reset, `in_ready` is 1, `irq` is 0, and both the status word (offset 0) and the data word (offset 1) read 0.
- R2: A character accepted at an edge appears in data word bits 7:0 from the next cycle. From that cycle, status bit 15 (waiting flag) is 1 and `in_ready` is 0.
- R3: While the waiting flag is 1, `in_ready` is 0, offered characters are refused, and the data word keeps its value.
- R4: A bus read of the data word clears the waiting flag at the end of that cycle, so `in_ready` is 1 in the next cycle. A read of the status word changes nothing.
- R5: `irq` is 1 exactly when status bit 15 and status bit 14 (interrupt enable) are both 1.
- R6: A status write loads bit 14 from write data bit 14. Write data bit 15 has no effect on the waiting flag.
- R7: Writes to the data word change neither the character nor the waiting flag.
- R8: Data word bits 15:8 read 0. Status bits 13:0 read 0. Offsets 2 and 3 read 0.
- R9: If a data read and an offered character fall in the same cycle while the flag is 1, the read returns the old character and the offer is refused. The offer is taken at the following edge.
- R10: `bus_rdata` reflects register state in the same cycle that `bus_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character offered on the stream |
| in_ready | output | 1 | Slot free; a character is taken when valid and ready are both high |
| in_data | input | 8 | Offered character |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset: 0 status, 1 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due in the same cycle as the select. The bench drives stimulus at the falling edge and samples `bus_rdata` one time step later, before the next rising edge. Flag, `in_ready` and `irq` changes from a capture, a data read or an enable write are due one cycle after the edge that registers them. The bench therefore samples these after the following falling edge, never at a rising edge. The sweep offers every character value, alternates the enable, and checks each one through capture, a refused offer, a clearing read and the idle state after it.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  // Register word offsets on the bus
  localparam int STAT_OFS_DEF = 0;
  localparam int DATA_OFS_DEF = 1;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/kbd_bus_decode.sv
module kbd_bus_decode
  import kbd_port_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int STAT_OFS = STAT_OFS_DEF,
  parameter int DATA_OFS = DATA_OFS_DEF
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit_stat,
  output logic              hit_data,
  output acc_kind_e         acc
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  always_comb begin
    hit_stat = (bus_addr == STAT_A);
    hit_data = (bus_addr == DATA_A);
    if (!bus_sel)    acc = ACC_NONE;
    else if (bus_we) acc = ACC_WRITE;
    else             acc = ACC_READ;
  end
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              drain,
  output logic              full,
  output logic [CHAR_W-1:0] char_q
);
  logic take;

  // slot is free only when nothing waits; a drain frees it for the next cycle
  assign in_ready = !full;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      char_q <= '0;
    end else if (take) begin
      full   <= 1'b1;
      char_q <= in_data;
    end else if (drain) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/kbd_ctrl.sv
module kbd_ctrl
  import kbd_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         acc,
  input  logic              hit_stat,
  input  logic              hit_data,
  input  logic              ie_wbit,
  input  logic              full,
  input  logic [CHAR_W-1:0] char_q,
  output logic              drain,
  output logic              irq,
  output logic [WORD_W-1:0] rdata
);
  localparam int RDY_BIT = WORD_W - 1;
  localparam int IE_BIT  = WORD_W - 2;

  logic ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ie_q <= 1'b0;
    else if (acc == ACC_WRITE && hit_stat) ie_q <= ie_wbit;
  end

  assign drain = (acc == ACC_READ) && hit_data && full;
  assign irq   = full && ie_q;

  always_comb begin
    rdata = '0;
    if (hit_stat) begin
      rdata[RDY_BIT] = full;
      rdata[IE_BIT]  = ie_q;
    end else if (hit_data) begin
      rdata[CHAR_W-1:0] = char_q;
    end
  end
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_port_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CHAR_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int STAT_OFS = STAT_OFS_DEF,
  parameter int DATA_OFS = DATA_OFS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int IE_BIT = WORD_W - 2;

  acc_kind_e         acc;
  logic              hit_stat, hit_data, drain, full;
  logic [CHAR_W-1:0] char_q;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  kbd_bus_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .DATA_OFS(DATA_OFS)) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .hit_stat(hit_stat), .hit_data(hit_data), .acc(acc)
  );

  kbd_capture #(.CHAR_W(CHAR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .drain(drain), .full(full), .char_q(char_q)
  );

  kbd_ctrl #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .hit_stat(hit_stat), .hit_data(hit_data),
    .ie_wbit(bus_wdata[IE_BIT]), .full(full), .char_q(char_q),
    .drain(drain), .irq(irq), .rdata(bus_rdata)
  );
endmodule

// File: rtl/kbd_input_port_chk.sv
module kbd_input_port_chk #(
  parameter int ADDR_W   = 2,
  parameter int DATA_OFS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq
);
  logic data_rd;
  assign data_rd = bus_sel && !bus_we && (bus_addr == ADDR_W'(DATA_OFS));

  // R2
  capture_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  // R3
  hold_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !data_rd |=> !in_ready);
  // R4
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && data_rd |=> in_ready);
  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !in_ready);
  // R2
  no_spurious_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready);
endmodule

bind kbd_input_port kbd_input_port_chk #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .irq(irq)
);

// File: tb/kbd_input_port_tb.sv
module kbd_input_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  kbd_input_port u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus access; rdata sampled mid-cycle (R10)
  task automatic bus(input bit we, input logic [1:0] a, input logic [15:0] wd,
                     output logic [15:0] rd);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic offer(input logic [7:0] c, output bit took);
    in_valid = 1'b1; in_data = c;
    #1 took = in_ready;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    bit took;
    logic [15:0] exp_ie;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    bus(0, 2'd0, '0, rd); chk(rd == 16'h0, "R1 status", rd, 0);
    bus(0, 2'd1, '0, rd); chk(rd == 16'h0, "R1 data", rd, 0);

    // R6: bit 15 write ignored, bit 14 held
    bus(1, 2'd0, 16'hFFFF, rd);
    bus(0, 2'd0, '0, rd); chk(rd == 16'h4000, "R6 write", rd, 16'h4000);
    chk(irq == 1'b0, "R5 irq off without flag", irq, 0);
    chk(in_ready == 1'b1, "R6 flag not set", in_ready, 1);

    // R8 unmapped offsets
    bus(0, 2'd2, '0, rd); chk(rd == 16'h0, "R8 ofs2", rd, 0);
    bus(0, 2'd3, '0, rd); chk(rd == 16'h0, "R8 ofs3", rd, 0);

    // sweep every character with alternating enable
    for (int c = 0; c < 256; c++) begin
      exp_ie = (c % 2 == 1) ? 16'h4000 : 16'h0000;
      bus(1, 2'd0, exp_ie, rd);
      offer(8'(c), took);
      chk(took, "R2 accepted", took, 1);
      #1;
      chk(in_ready == 1'b0, "R2 ready low", in_ready, 0);
      chk(irq == exp_ie[14], "R5 irq", irq, exp_ie[14]);
      bus(0, 2'd0, '0, rd);
      chk(rd == (16'h8000 | exp_ie), "R2 status", rd, 16'h8000 | exp_ie);
      chk(in_ready == 1'b0, "R4 status read keeps flag", in_ready, 0);
      offer(8'(c) ^ 8'hFF, took);
      chk(!took, "R3 refused", took, 0);
      bus(1, 2'd1, 16'h00FF & ~16'(c), rd);
      bus(0, 2'd0, '0, rd);
      chk(rd[15] == 1'b1, "R7 data write keeps flag", rd[15], 1);
      bus(0, 2'd1, '0, rd);
      chk(rd == 16'(c), "R3 R7 R8 data", rd, c);
      #1;
      chk(in_ready == 1'b1, "R4 cleared", in_ready, 1);
      chk(irq == 1'b0, "R5 irq drops", irq, 0);
      bus(0, 2'd1, '0, rd);
      chk(rd == 16'(c), "R4 data held after clear", rd, c);
      bus(0, 2'd0, '0, rd);
      chk(rd == exp_ie, "R4 status idle", rd, exp_ie);
    end

    // R9 simultaneous read and offer
    bus(1, 2'd0, 16'h0000, rd);
    offer(8'h5A, took);
    in_valid = 1'b1; in_data = 8'hC3;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 2'd1;
    #1;
    chk(in_ready == 1'b0, "R9 refused same cycle", in_ready, 0);
    chk(bus_rdata == 16'h005A, "R9 old char", bus_rdata, 16'h005A);
    @(negedge clk);
    bus_sel = 1'b0;
    #1 chk(in_ready == 1'b1, "R9 ready next cycle", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    bus(0, 2'd0, '0, rd); chk(rd == 16'h8000, "R9 flag set", rd, 16'h8000);
    bus(0, 2'd1, '0, rd); chk(rd == 16'h00C3, "R9 new char", rd, 16'h00C3);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule